// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block holds the programmable burst settings of a synchronous DRAM and, for every read or write burst, steps through the column addresses in the programmed order. A mode write carries a 10-bit setting word. Once the word is accepted, it fixes the burst length, the ordering within a burst, and the read latency used by every later burst. A burst start strobe supplies the first column and the direction. A terminate input, or a new start, cuts the current burst short.

On every beat the block presents the column and a valid flag. For writes it produces a per-beat write strobe that honours the byte mask in the same cycle. For reads it produces a read-data-valid flag delayed by the programmed latency, and an output-enable that honours the mask two cycles after the mask is sampled. Bank state, refresh and the storage array belong to the surrounding controller.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, col_valid, wr_en, rd_valid, rd_oe and mode_err are low, and the mode is burst length 1, sequential order, read latency 2.
- R2: A mode write with a legal word is stored. Bits 2:0 select the length (000=1, 001=2, 010=4, 011=8, 111=whole row). Bit 3 selects the order (0 sequential, 1 interleaved). Bits 6:4 select the latency (010=2, 011=3). mode_err stays low.
- R3: A mode write is rejected, mode_err is high for exactly the one cycle after the edge that sampled it, and the stored mode is unchanged, in any of these cases: the length code is 100, 101 or 110; the latency code is not 010 or 011; bits 9:7 are non-zero; whole-row length is combined with interleaved order; or the write arrives while a burst is starting, running, or still has read data in flight.
- R4: In the cycle after the edge that samples start, col_valid is high and col_out equals start_col. Each further edge advances one beat. col_valid falls after the programmed number of beats.
- R5: In sequential order, beat k presents the start column with its low log2(length) bits replaced by (those bits + k) modulo the length.
- R6: In interleaved order, beat k presents the start column XOR k.
- R7: With whole-row length, the column increments and wraps from 511 to 0, and the burst continues until it is stopped or restarted.
- R8: stop without start ends the burst, and col_valid is low from the next cycle. A start sampled while a burst runs, with or without stop, begins the new burst at the next cycle.
- R9: For a read started at edge n, rd_valid is high for one cycle per beat, beginning in the cycle after edge n+CL-1.
- R10: wr_en is high exactly when col_valid is high for a write burst and dqm is low in that same cycle.
- R11: rd_oe equals rd_valid, except that when dqm is sampled high at edge m, rd_oe is low in the cycle after edge m+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_wr | input | 1 | Mode write strobe |
| mrs_code | input | 10 | Mode setting word |
| start | input | 1 | Burst start strobe |
| start_rd | input | 1 | 1 for a read burst, 0 for a write burst |
| start_col | input | COL_W | First column of the burst |
| stop | input | 1 | Burst terminate |
| dqm | input | 1 | Data mask |
| col_out | output | COL_W | Current column |
| col_valid | output | 1 | A beat is presented |
| wr_en | output | 1 | Write beat accepted (not masked) |
| rd_valid | output | 1 | Read data valid after latency |
| rd_oe | output | 1 | Read output enable after mask |
| mode_err | output | 1 | Mode write rejected (one cycle) |

## Verification
Two pairs of functions can collide in one cycle, and both are provoked. In the first, a mode write is issued on the same edge as a burst start. The pass condition is that the start is taken with the old length, mode_err pulses, and a later burst still runs four beats. In the second, start and stop are raised together in the middle of a burst. The pass condition is that the next cycle shows the new start column and the full new sequence instead of an idle cycle. The mask is also raised within running read and write bursts, so that the same-cycle write rule and the delayed read rule are each judged on a single beat.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int MODE_W = 10;

    typedef struct packed {
        logic [2:0] bl;
        logic       ilv;
        logic [2:0] cl;
    } mode_t;

    function automatic logic code_ok(input logic [MODE_W-1:0] c);
        logic bl_ok;
        logic cl_ok;
        bl_ok = (c[2:0] inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111});
        cl_ok = (c[6:4] == 3'd2) || (c[6:4] == 3'd3);
        return bl_ok && cl_ok && (c[9:7] == 3'b000) && !((c[2:0] == 3'b111) && c[3]);
    endfunction

endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
    import bcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [MODE_W-1:0] code,
    input  logic              busy,
    output mode_t             mode,
    output logic              err
);
    typedef struct packed {
        mode_t mode;
        logic  err;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (wr) begin
            if (busy || !code_ok(code)) begin
                st_d.err = 1'b1;
            end else begin
                st_d.mode.bl  = code[2:0];
                st_d.mode.ilv = code[3];
                st_d.mode.cl  = code[6:4];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode.bl  <= 3'b000;
            st_q.mode.ilv <= 1'b0;
            st_q.mode.cl  <= 3'd2;
            st_q.err      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;
    assign err  = st_q.err;
endmodule

// File: rtl/bcg_col_seq.sv
module bcg_col_seq #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bl,
    input  logic             ilv,
    input  logic             start,
    input  logic             start_rd,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    output logic [COL_W-1:0] col,
    output logic             valid,
    output logic             is_rd
);
    typedef struct packed {
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] cnt;
        logic             valid;
        logic             rd;
    } st_t;

    st_t st_d, st_q;
    logic [COL_W-1:0] mask;
    logic             page;
    logic             last;

    always_comb begin
        case (bl)
            3'b000:  mask = '0;
            3'b001:  mask = COL_W'(1);
            3'b010:  mask = COL_W'(3);
            3'b011:  mask = COL_W'(7);
            default: mask = '1;
        endcase
    end

    assign page = (bl == 3'b111);
    assign last = st_q.valid && !page && (st_q.cnt == mask);

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.base  = start_col;
            st_d.cnt   = '0;
            st_d.valid = 1'b1;
            st_d.rd    = start_rd;
        end else if (stop) begin
            st_d.valid = 1'b0;
        end else if (st_q.valid) begin
            if (last) begin
                st_d.valid = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (ilv) begin
            col = (st_q.base & ~mask) | ((st_q.base ^ st_q.cnt) & mask);
        end else begin
            col = (st_q.base & ~mask) | ((st_q.base + st_q.cnt) & mask);
        end
    end

    assign valid = st_q.valid;
    assign is_rd = st_q.rd;
endmodule

// File: rtl/bcg_rd_pipe.sv
module bcg_rd_pipe #(
    parameter int LAT_MAX = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat,
    input  logic       dqm,
    input  logic [2:0] cl,
    output logic       rd_valid,
    output logic       rd_oe,
    output logic       pend
);
    localparam int SR_N = LAT_MAX - 1;

    typedef struct packed {
        logic [SR_N-1:0] sr;
        logic [1:0]      msk;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.sr[0] = beat;
        for (int i = 1; i < SR_N; i++) begin
            st_d.sr[i] = st_q.sr[i-1];
        end
        st_d.msk = {st_q.msk[0], dqm};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        for (int i = 0; i < SR_N; i++) begin
            if ((int'(cl) - 2) == i) rd_valid = st_q.sr[i];
        end
    end

    assign rd_oe = rd_valid & ~st_q.msk[1];
    assign pend  = |st_q.sr;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int LAT_MAX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrs_wr,
    input  logic [9:0]       mrs_code,
    input  logic             start,
    input  logic             start_rd,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    input  logic             dqm,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             wr_en,
    output logic             rd_valid,
    output logic             rd_oe,
    output logic             mode_err
);
    mode_t mode_q;
    logic  busy;
    logic  is_rd;
    logic  pend;

    assign busy = col_valid | start | pend;

    bcg_mode_reg u_mode (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (mrs_wr),
        .code (mrs_code),
        .busy (busy),
        .mode (mode_q),
        .err  (mode_err)
    );

    bcg_col_seq #(.COL_W(COL_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bl       (mode_q.bl),
        .ilv      (mode_q.ilv),
        .start    (start),
        .start_rd (start_rd),
        .start_col(start_col),
        .stop     (stop),
        .col      (col_out),
        .valid    (col_valid),
        .is_rd    (is_rd)
    );

    bcg_rd_pipe #(.LAT_MAX(LAT_MAX)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat    (col_valid & is_rd),
        .dqm     (dqm),
        .cl      (mode_q.cl),
        .rd_valid(rd_valid),
        .rd_oe   (rd_oe),
        .pend    (pend)
    );

    assign wr_en = col_valid & ~is_rd & ~dqm;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mrs_wr,
    input logic [9:0]       mrs_code,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             stop,
    input logic             dqm,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             wr_en,
    input logic             rd_valid,
    input logic             rd_oe,
    input logic             mode_err
);
    assert_first_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_valid && col_out == $past(start_col)));

    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !col_valid);

    assert_wr_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (col_valid && !dqm));

    assert_rd_oe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> rd_valid);

    assert_bad_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_wr && mrs_code[9:7] != 3'b000) |=> mode_err);

    assert_err_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> $past(mrs_wr));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mrs_wr   (mrs_wr),
    .mrs_code (mrs_code),
    .start    (start),
    .start_col(start_col),
    .stop     (stop),
    .dqm      (dqm),
    .col_out  (col_out),
    .col_valid(col_valid),
    .wr_en    (wr_en),
    .rd_valid (rd_valid),
    .rd_oe    (rd_oe),
    .mode_err (mode_err)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             mrs_wr;
    logic [9:0]       mrs_code;
    logic             start;
    logic             start_rd;
    logic [COL_W-1:0] start_col;
    logic             stop;
    logic             dqm;
    logic [COL_W-1:0] col_out;
    logic             col_valid;
    logic             wr_en;
    logic             rd_valid;
    logic             rd_oe;
    logic             mode_err;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mrs_wr(mrs_wr), .mrs_code(mrs_code),
        .start(start), .start_rd(start_rd), .start_col(start_col),
        .stop(stop), .dqm(dqm), .col_out(col_out), .col_valid(col_valid),
        .wr_en(wr_en), .rd_valid(rd_valid), .rd_oe(rd_oe), .mode_err(mode_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(input int base, input int k, input int blk, input bit ilv);
        int lo;
        if (ilv) return base ^ k;
        lo = base % blk;
        return (base - lo + ((lo + k) % blk)) % 512;
    endfunction

    task automatic do_mrs(input logic [9:0] code, input bit exp_err, input string req);
        @(negedge clk);
        mrs_wr = 1'b1;
        mrs_code = code;
        @(negedge clk);
        mrs_wr = 1'b0;
        #1;
        chk(mode_err == exp_err, req, int'(mode_err), int'(exp_err));
        @(negedge clk);
        #1;
        chk(mode_err == 1'b0, req, int'(mode_err), 0);
    endtask

    // dq_cyc: cycle index in which dqm is driven high (-10 means never)
    task automatic run_burst(input int col, input bit rd, input int len, input int blk,
                             input bit ilv, input int cl, input int dq_cyc, input int ncyc,
                             input string req);
        @(negedge clk);
        start = 1'b1;
        start_rd = rd;
        start_col = COL_W'(col);
        for (int j = 1; j <= ncyc; j++) begin
            bit ev;
            bit er;
            @(negedge clk);
            start = 1'b0;
            dqm = (j == dq_cyc);
            #1;
            ev = (j <= len);
            chk(col_valid == ev, {req, " valid"}, int'(col_valid), int'(ev));
            if (ev) chk(int'(col_out) == exp_col(col, j - 1, blk, ilv), {req, " column"},
                        int'(col_out), exp_col(col, j - 1, blk, ilv));
            if (rd) begin
                er = (j >= cl) && (j < cl + len);
                chk(rd_valid == er, "R9 rd_valid", int'(rd_valid), int'(er));
                chk(rd_oe == (er && j != dq_cyc + 2), "R11 rd_oe", int'(rd_oe),
                    int'(er && j != dq_cyc + 2));
            end else begin
                chk(wr_en == (ev && j != dq_cyc), "R10 wr_en", int'(wr_en),
                    int'(ev && j != dq_cyc));
            end
        end
        dqm = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; mrs_wr = 0; mrs_code = '0; start = 0; start_rd = 0;
        start_col = '0; stop = 0; dqm = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!col_valid && !wr_en && !rd_valid && !rd_oe && !mode_err, "R1 outputs idle",
            int'({col_valid, wr_en, rd_valid, rd_oe, mode_err}), 0);
        // R1: default mode is BL1, sequential, latency 2
        run_burst(5, 1, 1, 1, 0, 2, -10, 4, "R1 default read");
    endtask

    task automatic t_seq_bl4;
        do_mrs(10'h032, 0, "R2 BL4 seq CL3");
        run_burst(6, 0, 4, 4, 0, 3, 3, 6, "R5 seq write");
        run_burst(13, 1, 4, 4, 0, 3, -10, 8, "R5 seq read");
    endtask

    task automatic t_ilv_bl8;
        do_mrs(10'h02B, 0, "R2 BL8 ilv CL2");
        // R11: mask in cycle 4 removes the beat shown in cycle 6
        run_burst(9'h1A5, 1, 8, 8, 1, 2, 4, 12, "R6 ilv read");
    endtask

    task automatic t_reserved;
        do_mrs(10'h024, 1, "R3 bad length");
        do_mrs(10'h011, 1, "R3 bad latency");
        do_mrs(10'h0A2, 1, "R3 high bits");
        do_mrs(10'h02F, 1, "R3 page interleaved");
        run_burst(9'h0F3, 0, 8, 8, 1, 2, -10, 10, "R3 mode kept");
    endtask

    task automatic t_page;
        do_mrs(10'h027, 0, "R7 page mode");
        run_burst(510, 0, 20, 512, 0, 2, -10, 20, "R7 page wrap");
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        #1;
        chk(col_valid == 1'b0, "R8 stop", int'(col_valid), 0);
        chk(wr_en == 1'b0, "R8 stop wr_en", int'(wr_en), 0);
    endtask

    task automatic t_collide;
        int seq[4] = '{21, 22, 23, 20};
        do_mrs(10'h022, 0, "R2 BL4 seq CL2");
        @(negedge clk);
        start = 1'b1; start_rd = 1'b0; start_col = 9'd8;
        mrs_wr = 1'b1; mrs_code = 10'h030;
        @(negedge clk);
        start = 1'b0; mrs_wr = 1'b0;
        #1;
        chk(col_valid && col_out == 9'd8, "R4 first beat", int'(col_out), 8);
        chk(mode_err == 1'b1, "R3 busy write", int'(mode_err), 1);
        @(negedge clk);
        #1;
        chk(col_out == 9'd9, "R5 second beat", int'(col_out), 9);
        start = 1'b1; stop = 1'b1; start_col = 9'd21;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            start = 1'b0; stop = 1'b0;
            #1;
            chk(col_valid && int'(col_out) == seq[k], "R8 restart wins", int'(col_out), seq[k]);
        end
        @(negedge clk);
        #1;
        chk(col_valid == 1'b0, "R4 burst ends", int'(col_valid), 0);
    endtask

    initial begin
        t_reset();
        t_seq_bl4();
        t_ilv_bl8();
        t_reserved();
        t_page();
        t_collide();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200_000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule